// File: doc/BRIEF.md
# DMA Channel Event Interrupt Hub

This block gathers the per-channel event pulses of a multi-channel DMA engine. It presents them to software through a small register port and raises one interrupt line. Each channel reports three kinds of event as one-cycle pulses: transfer done, a first error kind and a second error kind. Every pulse sets a sticky raw flag for its channel and event kind. For each event kind, an enable mask decides which raw flags reach that kind's masked status word. A combined word then ORs the three masked words, one bit per channel. The interrupt output is a registered OR of that combined word.

Software clears flags by writing ones to a separate clear address for each event kind. Reading a clear address returns the raw flags of that kind, whatever the mask holds. The block also keeps a read/write priority word as plain storage. It shows the engine's per-channel busy lines in a read-only word. The register port completes every access in a single cycle: a write takes effect at the clock edge, and read data is combinational from the address. The port has no handshake, so there is no back-pressure and every access is accepted.

Top module: `dma_event_irq_hub`

## Requirements
- R1: While reset is asserted and after it is released, every raw flag, mask and the priority word read as 0, and irq_out is 0.
- R2: A pulse on done_pulse[i], err1_pulse[i] or err2_pulse[i] sets that channel's raw flag of that kind, whatever the mask holds. The flag stays set until it is cleared, and it reads back in bit i of the kind's clear address: 0x600 for done, 0x608 for error 1, 0x610 for error 2.
- R3: If an event pulse and a clear write hit the same flag in the same cycle, the flag ends set.
- R4: A write to a clear address clears exactly the flags whose wdata bit is 1. Flags whose wdata bit is 0 keep their value.
- R5: The mask registers sit at 0x18 (done), 0x20 (error 1) and 0x24 (error 2), each holding bits [15:0]. A mask bit of 1 enables its channel. The masked words read at 0x04 (done), 0x0C (error 1) and 0x10 (error 2) equal raw AND mask.
- R6: Bit i of the combined word at 0x00 is the OR of bit i of the three masked words. Writes to 0x00 have no effect.
- R7: irq_out is 1 in the cycle after any bit of the combined word was 1, and is 0 otherwise.
- R8: The priority word at 0x688 stores all 32 bits written and reads them back.
- R9: A read of 0x690 returns chan_busy in bits [15:0]. Writes to 0x690 have no effect.
- R10: A read of any other address returns 0. A write to any other address changes no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_pulse | input | 16 | Per-channel transfer-done pulses |
| err1_pulse | input | 16 | Per-channel error kind 1 pulses |
| err2_pulse | input | 16 | Per-channel error kind 2 pulses |
| chan_busy | input | 16 | Per-channel busy lines from the engine |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The bench aims at a pulse and a clear landing on the same flag in the same cycle. A design where the clear wins there would drop the event, and the raw read-back would show 0. A clear whose wdata has only some bits set must leave the other flags alone. Clearing the whole word, or taking the clear as a value to load, would wipe flags that are still pending. An event pulse under a zero mask must still latch its raw flag while both the masked word and irq_out stay low. Gating before the latch would lose the event once the mask is opened later. The bench also checks that irq_out lags the combined word by exactly one cycle, so an unregistered or doubly registered output is caught.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int unsigned NUM_KIND = 3;
  localparam int unsigned ADR_W    = 12;

  localparam logic [ADR_W-1:0] OFS_COMBINED = 12'h000;
  localparam logic [ADR_W-1:0] OFS_PRIO     = 12'h688;
  localparam logic [ADR_W-1:0] OFS_BUSY     = 12'h690;

  // kind 0 = transfer done, 1 = error kind 1, 2 = error kind 2
  function automatic logic [ADR_W-1:0] masked_ofs(input int k);
    case (k)
      0:       return 12'h004;
      1:       return 12'h00C;
      default: return 12'h010;
    endcase
  endfunction

  function automatic logic [ADR_W-1:0] enable_ofs(input int k);
    case (k)
      0:       return 12'h018;
      1:       return 12'h020;
      default: return 12'h024;
    endcase
  endfunction

  function automatic logic [ADR_W-1:0] clear_ofs(input int k);
    case (k)
      0:       return 12'h600;
      1:       return 12'h608;
      default: return 12'h610;
    endcase
  endfunction
endpackage

// File: rtl/dmairq_kind_bank.sv
module dmairq_kind_bank
  import dmairq_pkg::*;
#(
  parameter int unsigned NCH    = 16,
  parameter int unsigned DATA_W = 32,
  parameter int          KIND   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ev,
  input  logic              bus_wr,
  input  logic [ADR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [NCH-1:0]    raw,
  output logic [NCH-1:0]    enable,
  output logic [NCH-1:0]    masked
);
  localparam logic [ADR_W-1:0] CLR_A = clear_ofs(KIND);
  localparam logic [ADR_W-1:0] ENA_A = enable_ofs(KIND);

  logic [NCH-1:0] clr_vec;
  logic [NCH-1:0] raw_q, ena_q;

  assign clr_vec = (bus_wr && bus_addr == CLR_A) ? bus_wdata[NCH-1:0] : '0;

  // set has priority over clear on the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= (raw_q & ~clr_vec) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           ena_q <= '0;
    else if (bus_wr && bus_addr == ENA_A) ena_q <= bus_wdata[NCH-1:0];
  end

  assign raw    = raw_q;
  assign enable = ena_q;
  assign masked = raw_q & ena_q;

  a_r3_event_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((raw_q & $past(ev)) == $past(ev)));

  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~ev) != '0) |=> ((raw_q & $past(clr_vec & ~ev)) == '0));
endmodule

// File: rtl/dmairq_readmux.sv
module dmairq_readmux
  import dmairq_pkg::*;
#(
  parameter int unsigned NCH    = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic [ADR_W-1:0]             addr,
  input  logic [NUM_KIND-1:0][NCH-1:0] raw,
  input  logic [NUM_KIND-1:0][NCH-1:0] enable,
  input  logic [NUM_KIND-1:0][NCH-1:0] masked,
  input  logic [NCH-1:0]               combined,
  input  logic [NCH-1:0]               busy,
  input  logic [DATA_W-1:0]            prio,
  output logic [DATA_W-1:0]            rdata
);
  always_comb begin
    rdata = '0;
    if (addr == OFS_COMBINED) rdata[NCH-1:0] = combined;
    if (addr == OFS_BUSY)     rdata[NCH-1:0] = busy;
    if (addr == OFS_PRIO)     rdata          = prio;
    for (int k = 0; k < NUM_KIND; k++) begin
      if (addr == masked_ofs(k)) rdata[NCH-1:0] = masked[k];
      if (addr == enable_ofs(k)) rdata[NCH-1:0] = enable[k];
      if (addr == clear_ofs(k))  rdata[NCH-1:0] = raw[k];
    end
  end
endmodule

// File: rtl/dma_event_irq_hub.sv
module dma_event_irq_hub
  import dmairq_pkg::*;
#(
  parameter int unsigned NCH    = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    done_pulse,
  input  logic [NCH-1:0]    err1_pulse,
  input  logic [NCH-1:0]    err2_pulse,
  input  logic [NCH-1:0]    chan_busy,
  input  logic              bus_wr,
  input  logic [ADR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  logic [NUM_KIND-1:0][NCH-1:0] ev_all, raw_all, ena_all, msk_all;
  logic [NCH-1:0]    status_w;
  logic [DATA_W-1:0] prio_q;
  logic              irq_q;

  assign ev_all[0] = done_pulse;
  assign ev_all[1] = err1_pulse;
  assign ev_all[2] = err2_pulse;

  for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
    dmairq_kind_bank #(.NCH(NCH), .DATA_W(DATA_W), .KIND(k)) u_bank (
      .clk(clk), .rst_n(rst_n), .ev(ev_all[k]),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .raw(raw_all[k]), .enable(ena_all[k]), .masked(msk_all[k])
    );
  end

  always_comb begin
    status_w = '0;
    for (int k = 0; k < NUM_KIND; k++) status_w |= msk_all[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              prio_q <= '0;
    else if (bus_wr && bus_addr == OFS_PRIO) prio_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |status_w;
  end
  assign irq_out = irq_q;

  dmairq_readmux #(.NCH(NCH), .DATA_W(DATA_W)) u_rmux (
    .addr(bus_addr), .raw(raw_all), .enable(ena_all), .masked(msk_all),
    .combined(status_w), .busy(chan_busy), .prio(prio_q), .rdata(bus_rdata)
  );

  a_r7_irq_lags_status: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq_out == $past(|status_w)));

  a_r5_zero_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == enable_ofs(0) && bus_wdata[NCH-1:0] == '0)
      |=> (msk_all[0] == '0));

  a_r8_prio_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OFS_PRIO) |=> $stable(prio_q));
endmodule

// File: tb/sim_dma_event_irq_hub.sv
`timescale 1ns/1ps
module sim_dma_event_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ev_d = '0, ev_1 = '0, ev_2 = '0, busy = '0;
  logic        wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_event_irq_hub u0 (
    .clk(clk), .rst_n(rst_n), .done_pulse(ev_d), .err1_pulse(ev_1),
    .err2_pulse(ev_2), .chan_busy(busy), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq)
  );

  // behavioural reference
  logic [15:0] m_raw [3];
  logic [15:0] m_ena [3];
  logic [31:0] m_prio;
  logic        m_irq;

  function automatic logic [11:0] clr_a(int k);  return (k==0) ? 12'h600 : (k==1) ? 12'h608 : 12'h610; endfunction
  function automatic logic [11:0] ena_a(int k);  return (k==0) ? 12'h018 : (k==1) ? 12'h020 : 12'h024; endfunction
  function automatic logic [11:0] msk_a(int k);  return (k==0) ? 12'h004 : (k==1) ? 12'h00C : 12'h010; endfunction

  function automatic logic [15:0] m_status();
    logic [15:0] s = '0;
    for (int k = 0; k < 3; k++) s |= m_raw[k] & m_ena[k];
    return s;
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    if (a == 12'h000) return {16'h0, m_status()};
    if (a == 12'h688) return m_prio;
    if (a == 12'h690) return {16'h0, busy};
    for (int k = 0; k < 3; k++) begin
      if (a == msk_a(k)) return {16'h0, m_raw[k] & m_ena[k]};
      if (a == ena_a(k)) return {16'h0, m_ena[k]};
      if (a == clr_a(k)) return {16'h0, m_raw[k]};
    end
    return 32'h0;
  endfunction

  task automatic model_step();
    logic [15:0] evs [3];
    evs[0] = ev_d; evs[1] = ev_1; evs[2] = ev_2;
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) begin m_raw[k] = '0; m_ena[k] = '0; end
      m_prio = '0; m_irq = 1'b0;
    end else begin
      m_irq = |m_status();
      for (int k = 0; k < 3; k++) begin
        if (wr && addr == clr_a(k)) m_raw[k] &= ~wdata[15:0];
        m_raw[k] |= evs[k];
        if (wr && addr == ena_a(k)) m_ena[k] = wdata[15:0];
      end
      if (wr && addr == 12'h688) m_prio = wdata;
    end
  endtask

  task automatic check(string tag);
    logic [31:0] exp_r = m_read(addr);
    checks++;
    if (rdata !== exp_r) begin
      errors++;
      $display("FAIL %s: rdata @%h actual=%h expected=%h", tag, addr, rdata, exp_r);
    end
    checks++;
    if (irq !== m_irq) begin
      errors++;
      $display("FAIL %s: irq_out actual=%b expected=%b", tag, irq, m_irq);
    end
  endtask

  // one clock: update model for the edge just passed, drive new inputs, compare
  task automatic cyc(string tag, logic [15:0] d, logic [15:0] e1, logic [15:0] e2,
                     logic w, logic [11:0] a, logic [31:0] wd);
    @(negedge clk);
    model_step();
    ev_d = d; ev_1 = e1; ev_2 = e2; wr = w; addr = a; wdata = wd;
    #1 check(tag);
  endtask

  task automatic rd(string tag, logic [11:0] a);
    cyc(tag, '0, '0, '0, 1'b0, a, '0);
  endtask

  task automatic wrt(string tag, logic [11:0] a, logic [31:0] wd);
    cyc(tag, '0, '0, '0, 1'b1, a, wd);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    for (int k = 0; k < 3; k++) begin m_raw[k] = '0; m_ena[k] = '0; end
    m_prio = '0; m_irq = 0;
    rd("R1", 12'h000); rd("R1", 12'h600); rd("R1", 12'h018);
    rst_n = 1'b1;
    rd("R1", 12'h688); rd("R1", 12'h608); rd("R1", 12'h024);

    // R5 enable done kind, then R2 pulse and R6/R7 combined + irq
    wrt("R5", 12'h018, 32'h0000_FFFF);
    cyc("R2", 16'h0008, '0, '0, 1'b0, 12'h600, '0);
    rd("R6", 12'h000);
    rd("R7", 12'h004);
    rd("R7", 12'h000);

    // R2: error 1 under zero mask latches raw, no masked bit
    cyc("R2", '0, 16'h0020, '0, 1'b0, 12'h608, '0);
    rd("R2", 12'h608);
    rd("R5", 12'h00C);
    wrt("R5", 12'h020, 32'h0000_0020);
    rd("R6", 12'h000);
    rd("R7", 12'h00C);

    // R4: partial clear leaves other bits
    cyc("R2", 16'h0101, '0, '0, 1'b0, 12'h600, '0);
    wrt("R4", 12'h600, 32'h0000_0100);
    rd("R4", 12'h600);
    wrt("R4", 12'h608, 32'h0000_0000);
    rd("R4", 12'h608);

    // R3: set and clear collide
    cyc("R3", 16'h0100, '0, '0, 1'b1, 12'h600, 32'h0000_FFFF);
    rd("R3", 12'h600);
    cyc("R3", '0, '0, 16'h0004, 1'b1, 12'h610, 32'h0000_0004);
    rd("R3", 12'h610);

    // clear everything; irq must drop (R7)
    wrt("R4", 12'h600, 32'h0000_FFFF);
    wrt("R4", 12'h608, 32'h0000_FFFF);
    wrt("R4", 12'h610, 32'h0000_FFFF);
    rd("R7", 12'h000); rd("R7", 12'h000);

    // R8 priority storage, R9 busy, R10 unmapped / R6 RO write
    wrt("R8", 12'h688, 32'hA5C3_0F1E);
    rd("R8", 12'h688);
    busy = 16'hBEEF;
    rd("R9", 12'h690);
    wrt("R9", 12'h690, 32'h0);
    rd("R9", 12'h690);
    wrt("R10", 12'h7FC, 32'hFFFF_FFFF);
    rd("R10", 12'h7FC); rd("R10", 12'h014); rd("R10", 12'h604);
    wrt("R6", 12'h000, 32'hFFFF_FFFF);
    rd("R6", 12'h000);

    // mixed traffic, every cycle compared against the model
    for (int n = 0; n < 600; n++) begin
      logic [11:0] al [15] = '{12'h000, 12'h004, 12'h00C, 12'h010, 12'h018, 12'h020,
                               12'h024, 12'h600, 12'h608, 12'h610, 12'h688, 12'h690,
                               12'h7FC, 12'h014, 12'h60C};
      logic [15:0] pd, p1, p2;
      pd = ($urandom_range(3) == 0) ? 16'($urandom) : '0;
      p1 = ($urandom_range(5) == 0) ? 16'($urandom) : '0;
      p2 = ($urandom_range(5) == 0) ? 16'($urandom) : '0;
      busy = 16'($urandom);
      cyc("R2", pd, p1, p2, 1'($urandom), al[$urandom_range(14)], $urandom);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule